// File: doc/BRIEF.md
# Sequential Non-Restoring Unsigned Divider

This block divides one unsigned W-bit integer by another over a series of clock cycles. It produces the quotient and the remainder. A pulse on `start` while the unit is idle captures both operands. The unit then runs one partial-remainder step per clock. In each step the running remainder is shifted left by one bit and takes in the next dividend bit. The divisor is then either subtracted or added, depending on the sign the running remainder had before the shift. No step ever undoes a subtraction.

When the last step is done, the collected digits are converted into ordinary binary. This digit form treats a stored 0 as a weight of −1. If the last remainder came out negative, one final cycle lowers the quotient by one and adds the divisor back to the remainder. A zero divisor skips the iterations entirely. It reports at once with a flag, an all-ones quotient and the dividend as the remainder.

Results stay on the outputs until the next operation completes, so a consumer may read them at any time after `done`.

Top module: `seq_divider`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `busy`, `done` and `div_zero` are 0, and `quotient` and `remainder` are 0.
- R2: When `start` is sampled high while idle with a nonzero divisor, `busy` is high from the next cycle on. `done` is high in the cycle that begins W+1 clock edges after the sampling edge, and in that same cycle `busy` is low again.
- R3: For a nonzero divisor, the reported `quotient` equals floor(dividend / divisor) and `remainder` equals dividend mod divisor, for any W-bit operands.
- R4: When `start` is sampled with a divisor of zero, `done` and `div_zero` are high in the very next cycle, `quotient` is all ones, `remainder` equals the dividend, and `busy` stays low.
- R5: A completed operation with a nonzero divisor leaves `div_zero` at 0, even if the previous operation had raised it.
- R6: `start` is ignored while `busy` is high. The running operation finishes with the results for its original operands, with its normal latency, and no extra `done` follows.
- R7: `done` is high for exactly one cycle per accepted operation.
- R8: `quotient`, `remainder` and `div_zero` change only in a cycle where `done` is high. Operand inputs changing without `start` leave them unchanged.
- R9: Boundary operands give exact results: a divisor larger than the dividend gives quotient 0 and remainder equal to the dividend; a divisor of 1 gives the dividend as quotient and remainder 0; a dividend of 0 gives 0 and 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request to begin a division; sampled only while idle |
| dividend | input | W | Unsigned numerator, captured with start |
| divisor | input | W | Unsigned denominator, captured with start |
| busy | output | 1 | Iterations or the fix-up cycle are in progress |
| done | output | 1 | One-cycle pulse when results are valid |
| quotient | output | W | Unsigned quotient, held until the next completion |
| remainder | output | W | Unsigned remainder, held until the next completion |
| div_zero | output | 1 | Last completed operation had a zero divisor |

## Verification
The bench builds the divider with W = 8. At that width, complete sweeps over every divisor value for the extreme dividends 0, 1, 127, 128 and 255 fit easily within the run. This puts every divisor-greater-than-dividend case, every divide-by-one case and the zero divisor within reach. A few hundred random operand pairs then exercise both signs of the final partial remainder, so the quotient decrement and the remainder add-back are taken many times. The narrow width also keeps the iteration count small, so that `start` pulses injected mid-run and long idle stretches with wiggling inputs cost little.

// File: rtl/seq_divider.sv
module seq_divider #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] quotient,
  output logic [W-1:0] remainder,
  output logic         div_zero
);
  localparam int CW = $clog2(W + 1);

  typedef enum logic [1:0] {IDLE, RUN, FIX} state_t;

  state_t         st;
  logic [W:0]     prem;
  logic [W-1:0]   qsh;
  logic [W-1:0]   dvs;
  logic [CW-1:0]  cnt;

  logic [W:0] shifted;
  logic [W:0] step;
  logic [W:0] raw2;
  logic [W:0] conv;
  logic [W:0] fixrem;
  logic       neg_end;

  assign shifted = {prem[W-1:0], qsh[W-1]};
  assign step    = prem[W] ? shifted + {1'b0, dvs} : shifted - {1'b0, dvs};
  assign neg_end = prem[W];
  assign raw2    = {1'b1, qsh[W-1:1], 1'b0};
  assign conv    = raw2 - {1'b0, {W{1'b1}}};
  assign fixrem  = prem + {1'b0, dvs};
  assign busy    = (st != IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= IDLE;
      prem      <= '0;
      qsh       <= '0;
      dvs       <= '0;
      cnt       <= '0;
      done      <= 1'b0;
      quotient  <= '0;
      remainder <= '0;
      div_zero  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        IDLE: begin
          if (start) begin
            if (divisor == '0) begin
              quotient  <= '1;
              remainder <= dividend;
              div_zero  <= 1'b1;
              done      <= 1'b1;
            end else begin
              prem <= '0;
              qsh  <= dividend;
              dvs  <= divisor;
              cnt  <= CW'(W);
              st   <= RUN;
            end
          end
        end
        RUN: begin
          prem <= step;
          qsh  <= {qsh[W-2:0], ~step[W]};
          cnt  <= cnt - 1'b1;
          if (cnt == CW'(1)) st <= FIX;
        end
        FIX: begin
          quotient  <= conv[W-1:0] - {{(W-1){1'b0}}, neg_end};
          remainder <= neg_end ? fixrem[W-1:0] : prem[W-1:0];
          div_zero  <= 1'b0;
          done      <= 1'b1;
          st        <= IDLE;
        end
        default: st <= IDLE;
      endcase
    end
  end
endmodule

// File: rtl/seq_divider_chk.sv
module seq_divider_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         busy,
  input logic         done,
  input logic [W-1:0] quotient,
  input logic [W-1:0] remainder,
  input logic         div_zero,
  input logic [W-1:0] dvs
);
  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R2
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  // R2
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R3
  rem_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !div_zero) |-> (remainder < dvs));

  // R4
  zero_q_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && div_zero) |-> (quotient == '1));

  // R4
  zero_nobusy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> (done || busy));

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!done) |-> ($stable(quotient) && $stable(remainder) && $stable(div_zero)));
endmodule

bind seq_divider seq_divider_chk #(.W(W)) chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .quotient(quotient), .remainder(remainder), .div_zero(div_zero), .dvs(dvs)
);

// File: tb/seq_divider_test.sv
`timescale 1ns/1ps
module seq_divider_test;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [W-1:0] dividend = '0;
  logic [W-1:0] divisor = '0;
  logic         busy, done, div_zero;
  logic [W-1:0] quotient, remainder;

  seq_divider #(.W(W)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .dividend(dividend), .divisor(divisor),
    .busy(busy), .done(done), .quotient(quotient), .remainder(remainder), .div_zero(div_zero)
  );

  always #4 clk = ~clk;

  typedef struct {
    logic [W-1:0] q;
    logic [W-1:0] r;
    logic         dz;
    string        tag;
  } exp_t;

  exp_t sbq[$];
  int nchk = 0;
  int nerr = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && done) begin
      if (sbq.size() == 0) begin
        check(1'b0, "R6 unexpected done", 1, 0);
      end else begin
        exp_t e;
        e = sbq.pop_front();
        check(quotient == e.q, {e.tag, " quotient"}, quotient, e.q);
        check(remainder == e.r, {e.tag, " remainder"}, remainder, e.r);
        check(div_zero == e.dz, {e.tag, " R5 div_zero"}, div_zero, e.dz);
      end
    end
  end

  task automatic run(input logic [W-1:0] a, input logic [W-1:0] b,
                     input string tag, input int poke);
    exp_t e;
    int lat;
    int want;
    while (busy) @(negedge clk);
    e.tag = tag;
    if (b == 0) begin
      e.q = '1; e.r = a; e.dz = 1'b1; want = 0;
    end else begin
      e.q = a / b; e.r = a % b; e.dz = 1'b0; want = W + 1;
    end
    sbq.push_back(e);
    dividend = a;
    divisor  = b;
    start    = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    while (!done && lat < 100) begin
      if (lat == poke) begin
        start = 1'b1; dividend = ~a; divisor = 8'd3;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      lat++;
    end
    start = 1'b0;
    if (b == 0) begin
      check(lat == want, "R4 latency", lat, want);
      check(!busy, "R4 busy low", busy, 0);
    end else begin
      check(lat == want, poke >= 0 ? "R6 latency" : "R2 latency", lat, want);
      check(!busy, "R2 busy low at done", busy, 0);
    end
    @(negedge clk);
    check(!done, "R7 done single cycle", done, 0);
  endtask

  initial begin
    #(8 * 190000);
    if (!finished) begin
      check(1'b0, "watchdog", 0, 1);
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] hq, hr;
    logic [W-1:0] edges [5];
    edges = '{8'd0, 8'd1, 8'd127, 8'd128, 8'd255};
    repeat (3) @(negedge clk);
    check(!busy && !done && !div_zero, "R1 flags in reset", {busy, done, div_zero}, 0);
    check(quotient == 0 && remainder == 0, "R1 results in reset", quotient, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !done && !div_zero, "R1 flags after reset", {busy, done, div_zero}, 0);
    check(quotient == 0 && remainder == 0, "R1 results after reset", remainder, 0);

    run(8'd200, 8'd7, "R3 basic", -1);
    run(8'd13, 8'd0, "R4 zero divisor", -1);
    run(8'd100, 8'd10, "R5 after zero", -1);
    run(8'd5, 8'd9, "R9 divisor above dividend", -1);
    run(8'd231, 8'd1, "R9 divide by one", -1);
    run(8'd0, 8'd77, "R9 zero dividend", -1);
    run(8'd255, 8'd255, "R3 equal operands", -1);
    run(8'd250, 8'd6, "R6 start while busy", 3);
    run(8'd99, 8'd4, "R6 start on last step", W - 1);

    hq = quotient; hr = remainder;
    for (int i = 0; i < 6; i++) begin
      dividend = 8'(i * 37); divisor = 8'(i + 1);
      @(negedge clk);
      check(!done, "R8 no done without start", done, 0);
    end
    check(quotient == hq, "R8 quotient held", quotient, hq);
    check(remainder == hr, "R8 remainder held", remainder, hr);

    foreach (edges[k]) begin
      for (int b = 0; b < 256; b++) begin
        run(edges[k], 8'(b), "R9 sweep", -1);
      end
    end

    for (int i = 0; i < 600; i++) begin
      logic [W-1:0] a, b;
      a = 8'($urandom);
      b = 8'($urandom);
      run(a, b, "R3 random", -1);
    end

    repeat (W + 4) @(negedge clk);
    check(sbq.size() == 0, "R6 scoreboard drained", sbq.size(), 0);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule